// File: doc/BRIEF.md
# Eight-Channel ADC Conversion Sequencer

This block sequences conversions for an eight-channel analog-to-digital converter whose front end lies outside it. Each channel's sample reaches the block as a ready-made digital code on its own slice of a wide input bus, and that code is captured at the last conversion clock of the conversion. Software drives the block through a small word-wide register bus. The bus carries a control word, an interrupt-enable word, one global result word and one result word per channel.

A prescaler turns the bus clock into a conversion clock. The block then runs in one of two ways. In the first, a single conversion of the lowest selected channel starts at once or on a chosen edge of an external trigger. In the second, the selected channels are scanned without a break, and fewer clocks per conversion buy speed at the cost of low-order result bits. Each finished conversion sets done and overrun flags. Reading a result word clears its flags. One interrupt line follows either the global done flag or the done flags of the enabled channels.

Top module: `adc_seq`

## Requirements
- R1: A conversion of N conversion clocks that starts at bus clock edge k completes at edge k + N*(div+1), where div is the control field at bits [15:8]. Results and flags change at that edge and at no earlier one.
- R2: A conversion that is not part of a scan takes 11 conversion clocks and keeps all 10 result bits.
- R3: In a scan, the code c in control bits [18:16] gives 11-c conversion clocks. The lowest c result bits then read as zero.
- R4: With the scan bit (control bit 19) set, the channels selected in control bits [7:0] are converted one after another, with no idle cycle between them. The order is ascending index, wrapping to the lowest selected channel. Clearing the bit lets the running conversion finish, and no further conversion starts.
- R5: The start field, control bits [22:21], selects the start source: 0 never starts, 1 starts one conversion on the control write that holds it, and 2 starts one conversion on each trigger edge seen while the block is idle. Control bit 23 picks the rising edge when set and the falling edge when clear, and the opposite edge is ignored.
- R6: While the power bit (control bit 20) is clear, no conversion starts. Clearing it aborts a running conversion, and nothing is recorded.
- R7: On completion the global word (address 1) holds done in bit 31, the channel in bits [14:12] and the result in bits [9:0]. The channel word (address 8+channel) holds done in bit 31 and the same result.
- R8: A completion that finds done already set in a word also sets that word's overrun flag, bit 30.
- R9: When interrupt-enable bit 8 (address 2) is set, the interrupt follows only the global done flag. When it is clear, the interrupt is high while any channel whose enable bit in [7:0] is set has its done flag set.
- R10: A read of a channel word clears its done and overrun flags. A read of the global word clears global done and overrun, and also done in the word of the channel it reports. A completion in the same cycle as such a read wins over the clear.
- R11: After reset every register reads zero and the interrupt is low. A read returns the register's value one cycle later, and the read-data bus is zero in cycles that follow no read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_addr | input | 4 | Register word address |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe, which clears flags as a side effect |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, one cycle after the strobe |
| trig_i | input | 1 | External conversion trigger |
| sample_i | input | NCH*RES_W | Digital sample codes, channel c at slice c*RES_W |
| irq_o | output | 1 | Conversion-complete interrupt |

## Verification
The bench builds the block with its default parameters: eight channels, 10-bit results and an 8-bit divider field. This makes the full channel decode, the wrap of a scan across three spread-out channels and every result-masking width available. It runs conversions with divider values 0, 1 and 3 and with a scan code of 3. These settings make exact completion-edge timing, truncation of three low bits, and an abort in the middle of a long conversion all observable within a few hundred cycles.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;

    // conversion clocks at full precision
    localparam int unsigned FULL_CLOCKS = 11;

    localparam logic [3:0] ADDR_CTRL   = 4'd0;
    localparam logic [3:0] ADDR_GLOBAL = 4'd1;
    localparam logic [3:0] ADDR_INTEN  = 4'd2;

    typedef enum logic [1:0] {
        START_NONE = 2'd0,
        START_NOW  = 2'd1,
        START_TRIG = 2'd2,
        START_RSVD = 2'd3
    } start_mode_e;

    function automatic logic [3:0] clocks_for_code(input logic [2:0] code);
        return 4'(FULL_CLOCKS) - {1'b0, code};
    endfunction

endpackage

// File: rtl/adc_seq_prescale.sv
module adc_seq_prescale #(
    parameter int DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic [DIV_W-1:0] div,
    output logic             tick
);
    logic [DIV_W-1:0] cnt_d, cnt_q;

    always_comb begin
        tick  = run && (cnt_q == div);
        cnt_d = (tick || !run) ? '0 : cnt_q + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    // R1: every conversion clock restarts the bus-clock count
    assert_tick_restart_R1: assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> (cnt_q == '0));

endmodule

// File: rtl/adc_seq_pick.sv
module adc_seq_pick #(
    parameter int NCH  = 8,
    parameter int CH_W = 3
) (
    input  logic [NCH-1:0]  mask,
    input  logic [CH_W-1:0] cur,
    output logic [CH_W-1:0] first,
    output logic [CH_W-1:0] nxt,
    output logic            any
);
    logic found;

    always_comb begin
        first = '0;
        nxt   = '0;
        found = 1'b0;
        any   = |mask;
        // descending walk: the last hit is the lowest index
        for (int i = NCH - 1; i >= 0; i--) begin
            if (mask[i]) begin
                first = CH_W'(i);
                if (i > int'(cur)) begin
                    nxt   = CH_W'(i);
                    found = 1'b1;
                end
            end
        end
        if (!found) nxt = first;
    end

endmodule

// File: rtl/adc_seq.sv
module adc_seq
    import adc_seq_pkg::*;
#(
    parameter int NCH   = 8,
    parameter int RES_W = 10,
    parameter int DIV_W = 8
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [3:0]           bus_addr,
    input  logic                 bus_wr,
    input  logic                 bus_rd,
    input  logic [31:0]          bus_wdata,
    output logic [31:0]          bus_rdata,
    input  logic                 trig_i,
    input  logic [NCH*RES_W-1:0] sample_i,
    output logic                 irq_o
);
    // layout assumes NCH <= 8, DIV_W <= 8, RES_W <= 12
    localparam int CH_W = $clog2(NCH);

    typedef struct packed {
        logic [NCH-1:0]            sel;
        logic [DIV_W-1:0]          div;
        logic [2:0]                code;
        logic                      burst;
        logic                      pwr;
        start_mode_e               mode;
        logic                      rise;
        logic [NCH-1:0]            ien;
        logic                      gien;
        logic                      busy;
        logic [CH_W-1:0]           chan;
        logic [3:0]                nclk;
        logic [3:0]                tcnt;
        logic [2:0]                ccode;
        logic [RES_W-1:0]          gres;
        logic [CH_W-1:0]           gchan;
        logic                      gdone;
        logic                      govr;
        logic [NCH-1:0][RES_W-1:0] cres;
        logic [NCH-1:0]            cdone;
        logic [NCH-1:0]            covr;
        logic                      trig_prev;
        logic [31:0]               rdata;
    } state_t;

    state_t st_d, st_q;

    logic            tick;
    logic            wr_ctrl, wr_ien;
    logic [NCH-1:0]  sel_eff;
    logic [CH_W-1:0] pick_first, pick_next;
    logic            pick_any;
    logic            trig_hit;
    logic            done_evt, chain_evt;
    logic [RES_W-1:0] sample_now, res_now;
    logic [CH_W-1:0] rd_idx;
    logic            rd_chan;

    assign wr_ctrl = bus_wr && (bus_addr == ADDR_CTRL);
    assign wr_ien  = bus_wr && (bus_addr == ADDR_INTEN);
    assign sel_eff = wr_ctrl ? bus_wdata[NCH-1:0] : st_q.sel;
    assign rd_idx  = bus_addr[CH_W-1:0];
    assign rd_chan = bus_addr[3] && (int'(rd_idx) < NCH);

    wire unused_wbits = ^{bus_wdata[31:24]};

    adc_seq_prescale #(.DIV_W(DIV_W)) u_prescale (
        .clk  (clk),
        .rst_n(rst_n),
        .run  (st_q.busy),
        .div  (st_q.div),
        .tick (tick)
    );

    adc_seq_pick #(.NCH(NCH), .CH_W(CH_W)) u_pick (
        .mask (sel_eff),
        .cur  (st_q.chan),
        .first(pick_first),
        .nxt  (pick_next),
        .any  (pick_any)
    );

    always_comb begin
        st_d           = st_q;
        st_d.rdata     = '0;
        st_d.trig_prev = trig_i;
        done_evt       = 1'b0;
        chain_evt      = 1'b0;
        sample_now     = sample_i[int'(st_q.chan)*RES_W +: RES_W];
        res_now        = sample_now & ({RES_W{1'b1}} << st_q.ccode);

        if (wr_ctrl) begin
            st_d.sel   = bus_wdata[NCH-1:0];
            st_d.div   = bus_wdata[8 +: DIV_W];
            st_d.code  = bus_wdata[18:16];
            st_d.burst = bus_wdata[19];
            st_d.pwr   = bus_wdata[20];
            st_d.mode  = start_mode_e'(bus_wdata[22:21]);
            st_d.rise  = bus_wdata[23];
        end
        if (wr_ien) begin
            st_d.ien  = bus_wdata[NCH-1:0];
            st_d.gien = bus_wdata[8];
        end

        // reads return the old value, then clear flags
        if (bus_rd) begin
            if (bus_addr == ADDR_CTRL) begin
                st_d.rdata = {8'b0, st_q.rise, st_q.mode, st_q.pwr, st_q.burst,
                              st_q.code, 8'(st_q.div), 8'(st_q.sel)};
            end else if (bus_addr == ADDR_GLOBAL) begin
                st_d.rdata = {st_q.gdone, st_q.govr, 15'b0, 3'(st_q.gchan), 12'(st_q.gres)};
                st_d.gdone = 1'b0;
                st_d.govr  = 1'b0;
                st_d.cdone[st_q.gchan] = 1'b0;
            end else if (bus_addr == ADDR_INTEN) begin
                st_d.rdata = {23'b0, st_q.gien, 8'(st_q.ien)};
            end else if (rd_chan) begin
                st_d.rdata = {st_q.cdone[rd_idx], st_q.covr[rd_idx], 18'b0, 12'(st_q.cres[rd_idx])};
                st_d.cdone[rd_idx] = 1'b0;
                st_d.covr[rd_idx]  = 1'b0;
            end
        end

        trig_hit = st_d.rise ? (trig_i && !st_q.trig_prev) : (!trig_i && st_q.trig_prev);

        if (!st_d.pwr) begin
            st_d.busy = 1'b0;
            st_d.tcnt = '0;
        end else if (st_q.busy) begin
            if (tick) begin
                if (st_q.tcnt == st_q.nclk - 4'd1) begin
                    done_evt = 1'b1;
                    st_d.covr[st_q.chan]  = st_d.covr[st_q.chan] | st_d.cdone[st_q.chan];
                    st_d.cdone[st_q.chan] = 1'b1;
                    st_d.cres[st_q.chan]  = res_now;
                    st_d.govr  = st_d.govr | st_d.gdone;
                    st_d.gdone = 1'b1;
                    st_d.gres  = res_now;
                    st_d.gchan = st_q.chan;
                    st_d.tcnt  = '0;
                    if (st_d.burst && pick_any) begin
                        chain_evt  = 1'b1;
                        st_d.chan  = pick_next;
                        st_d.ccode = st_d.code;
                        st_d.nclk  = clocks_for_code(st_d.code);
                    end else begin
                        st_d.busy = 1'b0;
                    end
                end else begin
                    st_d.tcnt = st_q.tcnt + 4'd1;
                end
            end
        end else if (pick_any) begin
            if (st_d.burst) begin
                st_d.busy  = 1'b1;
                st_d.chan  = pick_first;
                st_d.tcnt  = '0;
                st_d.ccode = st_d.code;
                st_d.nclk  = clocks_for_code(st_d.code);
            end else if ((wr_ctrl && st_d.mode == START_NOW) ||
                         (st_d.mode == START_TRIG && trig_hit)) begin
                st_d.busy  = 1'b1;
                st_d.chan  = pick_first;
                st_d.tcnt  = '0;
                st_d.ccode = 3'd0;
                st_d.nclk  = clocks_for_code(3'd0);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign bus_rdata = st_q.rdata;
    assign irq_o     = st_q.gien ? st_q.gdone : |(st_q.cdone & st_q.ien);

    // R6: a powered-down block is never converting
    assert_pwr_idle_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !st_q.pwr |-> !st_q.busy);

    // R1: the clock count stays inside the conversion length
    assert_conv_span_R1: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.busy |-> (st_q.tcnt < st_q.nclk));

    // R8: completing onto an unread channel result flags overrun
    assert_ovr_flag_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (done_evt && !bus_rd && st_q.cdone[st_q.chan]) |=> st_q.covr[$past(st_q.chan)]);

    // R10: a global read with no completion leaves global done clear
    assert_read_clear_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && bus_addr == ADDR_GLOBAL && !done_evt) |=> !st_q.gdone);

    // R9: in global mode the read that clears done drops the interrupt
    assert_gint_clear_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.gien && !wr_ien && bus_rd && bus_addr == ADDR_GLOBAL && !done_evt) |=> !irq_o);

    // R4: a scan moves upward or wraps to the lowest selected channel
    assert_scan_order_R4: assert property (@(posedge clk) disable iff (!rst_n)
        chain_evt |=> ((st_q.chan > $past(st_q.chan)) || (st_q.chan == $past(pick_first))));

endmodule

// File: tb/adc_seq_bench.sv
module adc_seq_bench;
    localparam int CLK_PERIOD = 10;
    localparam int NCH   = 8;
    localparam int RES_W = 10;

    logic                 clk = 1'b0;
    logic                 rst_n = 1'b0;
    logic [3:0]           bus_addr = '0;
    logic                 bus_wr = 1'b0;
    logic                 bus_rd = 1'b0;
    logic [31:0]          bus_wdata = '0;
    logic [31:0]          bus_rdata;
    logic                 trig_i = 1'b0;
    logic [NCH*RES_W-1:0] sample_i;
    logic                 irq_o;

    int checks = 0;
    int failures = 0;
    bit fin = 1'b0;
    int smp [NCH];

    always #(CLK_PERIOD/2) clk = ~clk;

    adc_seq u_adc_seq (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .trig_i(trig_i),
        .sample_i(sample_i), .irq_o(irq_o)
    );

    // ---------------- behavioural reference model ----------------
    int m_sel, m_div, m_code, m_burst, m_pwr, m_mode, m_rise, m_ien, m_gien;
    bit m_busy;
    int m_ch, m_len, m_cc, m_ticks, m_sub;
    int m_gres, m_gch;
    bit m_gdone, m_govr;
    int m_cres [NCH];
    bit m_cdone [NCH];
    bit m_covr [NCH];
    bit m_tp;
    logic [31:0] m_rd;
    bit m_irq;

    function automatic int first_sel(int sel);
        for (int j = 0; j < NCH; j++) if (sel[j]) return j;
        return 0;
    endfunction

    function automatic int next_sel(int sel, int cur);
        for (int j = 1; j <= NCH; j++) if (sel[(cur + j) % NCH]) return (cur + j) % NCH;
        return 0;
    endfunction

    always @(posedge clk) begin
        bit ob, tk, edge_ok;
        int ix;
        if (!rst_n) begin
            m_sel = 0; m_div = 0; m_code = 0; m_burst = 0; m_pwr = 0; m_mode = 0; m_rise = 0;
            m_ien = 0; m_gien = 0; m_busy = 0; m_ch = 0; m_len = 0; m_cc = 0; m_ticks = 0;
            m_sub = 0; m_gres = 0; m_gch = 0; m_gdone = 0; m_govr = 0; m_tp = 0; m_rd = 0; m_irq = 0;
            for (int j = 0; j < NCH; j++) begin m_cres[j] = 0; m_cdone[j] = 0; m_covr[j] = 0; end
        end else begin
            ob = m_busy;
            tk = m_busy && (m_sub == m_div);
            m_sub = (!m_busy || tk) ? 0 : m_sub + 1;
            m_rd = 0;
            if (bus_rd) begin
                if (bus_addr == 0)
                    m_rd = m_sel | (m_div << 8) | (m_code << 16) | (m_burst << 19) |
                           (m_pwr << 20) | (m_mode << 21) | (m_rise << 23);
                else if (bus_addr == 1)
                    m_rd = {m_gdone, m_govr, 30'(m_gch * 4096 + m_gres)};
                else if (bus_addr == 2)
                    m_rd = (m_gien << 8) | m_ien;
                else if (bus_addr >= 8) begin
                    ix = int'(bus_addr) - 8;
                    m_rd = {m_cdone[ix], m_covr[ix], 30'(m_cres[ix])};
                end
            end
            if (bus_wr && bus_addr == 0) begin
                m_sel = bus_wdata[7:0]; m_div = bus_wdata[15:8]; m_code = bus_wdata[18:16];
                m_burst = bus_wdata[19]; m_pwr = bus_wdata[20]; m_mode = bus_wdata[22:21];
                m_rise = bus_wdata[23];
            end
            if (bus_wr && bus_addr == 2) begin
                m_ien = bus_wdata[7:0]; m_gien = bus_wdata[8];
            end
            if (bus_rd && bus_addr == 1) begin
                m_gdone = 0; m_govr = 0; m_cdone[m_gch] = 0;
            end
            if (bus_rd && bus_addr >= 8) begin
                ix = int'(bus_addr) - 8;
                m_cdone[ix] = 0; m_covr[ix] = 0;
            end
            edge_ok = m_rise ? (trig_i && !m_tp) : (!trig_i && m_tp);
            m_tp = trig_i;
            if (!m_pwr) begin
                m_busy = 0;
            end else if (ob) begin
                if (tk) begin
                    if (m_ticks == m_len - 1) begin
                        int r;
                        r = (smp[m_ch] >> m_cc) << m_cc;
                        m_covr[m_ch] = m_covr[m_ch] | m_cdone[m_ch];
                        m_cdone[m_ch] = 1; m_cres[m_ch] = r;
                        m_govr = m_govr | m_gdone; m_gdone = 1; m_gres = r; m_gch = m_ch;
                        m_ticks = 0;
                        if (m_burst && m_sel != 0) begin
                            m_ch = next_sel(m_sel, m_ch); m_cc = m_code; m_len = 11 - m_code;
                        end else m_busy = 0;
                    end else m_ticks++;
                end
            end else if (m_sel != 0) begin
                if (m_burst) begin
                    m_busy = 1; m_ch = first_sel(m_sel); m_ticks = 0; m_cc = m_code; m_len = 11 - m_code;
                end else if ((bus_wr && bus_addr == 0 && m_mode == 1) || (m_mode == 2 && edge_ok)) begin
                    m_busy = 1; m_ch = first_sel(m_sel); m_ticks = 0; m_cc = 0; m_len = 11;
                end
            end
            m_irq = 0;
            if (m_gien) m_irq = m_gdone;
            else for (int j = 0; j < NCH; j++) if (m_cdone[j] && m_ien[j]) m_irq = 1;
        end
    end

    // cycle-by-cycle comparison against the model
    always @(negedge clk) begin
        if (rst_n && !fin) begin
            checks++;
            if (irq_o !== m_irq) begin
                failures++;
                $display("FAIL R9 model irq act=%0b exp=%0b t=%0t", irq_o, m_irq, $time);
            end
            checks++;
            if (bus_rdata !== m_rd) begin
                failures++;
                $display("FAIL R7 model rdata act=%h exp=%h t=%0t", bus_rdata, m_rd, $time);
            end
        end
    end

    // ---------------- directed helpers ----------------
    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s act=%h exp=%h", tag, act, exp);
        end
    endtask

    task automatic wait_n(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic do_write(input logic [3:0] a, input logic [31:0] d);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic do_read(input logic [3:0] a, output logic [31:0] d);
        bus_addr = a; bus_rd = 1'b1;
        @(negedge clk);
        d = bus_rdata; bus_rd = 1'b0;
    endtask

    function automatic logic [31:0] cw(int sel, int div, int code, bit burst, bit pwr, int mode, bit rise);
        return {8'b0, rise, 2'(mode), pwr, burst, 3'(code), 8'(div), 8'(sel)};
    endfunction

    function automatic logic [31:0] gw(bit done, bit ovr, int ch, int res);
        return {done, ovr, 15'b0, 3'(ch), 12'(res)};
    endfunction

    initial begin
        logic [31:0] v;
        for (int i = 0; i < NCH; i++) begin
            smp[i] = (i * 181 + 77) % 1024;
            sample_i[i*RES_W +: RES_W] = RES_W'(smp[i]);
        end
        wait_n(4);
        rst_n = 1'b1;
        wait_n(1);

        // R11 reset values
        chk("R11 irq after reset", 32'(irq_o), 32'd0);
        do_read(4'd0, v); chk("R11 ctrl reset", v, 32'd0);
        do_read(4'd1, v); chk("R11 global reset", v, 32'd0);
        do_read(4'd13, v); chk("R11 channel reset", v, 32'd0);
        do_read(4'd2, v); chk("R11 inten reset", v, 32'd0);

        // R6 powered down: immediate start has no effect
        do_write(4'd0, cw(8'h04, 1, 0, 0, 0, 1, 0));
        wait_n(40);
        do_read(4'd1, v); chk("R6 no conversion while off", v, 32'd0);

        // R1 R2 immediate start, divider 1, exact completion edge
        do_write(4'd2, 32'h0000_0004);
        do_write(4'd0, cw(8'h24, 1, 5, 0, 1, 1, 0));
        wait_n(21);
        chk("R1 irq low one edge early", 32'(irq_o), 32'd0);
        wait_n(1);
        chk("R1 irq at completion edge", 32'(irq_o), 32'd1);
        do_read(4'd10, v); chk("R2 R7 channel word full precision", v, gw(1, 0, 0, smp[2]));
        chk("R10 channel read drops irq", 32'(irq_o), 32'd0);
        do_read(4'd1, v); chk("R7 global word", v, gw(1, 0, 2, smp[2]));

        // R8 overrun on both words
        do_write(4'd0, cw(8'h24, 1, 0, 0, 1, 1, 0));
        wait_n(25);
        do_write(4'd0, cw(8'h24, 1, 0, 0, 1, 1, 0));
        wait_n(25);
        do_read(4'd10, v); chk("R8 channel overrun", v, gw(1, 1, 0, smp[2]));
        do_read(4'd1, v); chk("R8 global overrun", v, gw(1, 1, 2, smp[2]));

        // R9 global-done interrupt mode, R10 global read clears channel done
        do_write(4'd2, 32'h0000_0100);
        do_write(4'd0, cw(8'h24, 1, 0, 0, 1, 1, 0));
        wait_n(23);
        chk("R9 global mode irq", 32'(irq_o), 32'd1);
        do_read(4'd1, v); chk("R7 global after new conversion", v, gw(1, 0, 2, smp[2]));
        chk("R9 irq cleared by global read", 32'(irq_o), 32'd0);
        do_read(4'd10, v); chk("R10 global read cleared channel done", v, gw(0, 0, 0, smp[2]));

        // R5 trigger on rising edge, falling ignored
        do_write(4'd2, 32'h0);
        do_write(4'd0, cw(8'h08, 0, 0, 0, 1, 2, 1));
        trig_i = 1'b1;
        wait_n(15);
        do_read(4'd1, v); chk("R5 rising trigger start", v, gw(1, 0, 3, smp[3]));
        trig_i = 1'b0;
        wait_n(15);
        do_read(4'd1, v); chk("R5 falling edge ignored", v, gw(0, 0, 3, smp[3]));
        // falling-edge trigger
        do_write(4'd0, cw(8'h08, 0, 0, 0, 1, 2, 0));
        trig_i = 1'b1;
        wait_n(15);
        do_read(4'd1, v); chk("R5 rising edge ignored", v, gw(0, 0, 3, smp[3]));
        trig_i = 1'b0;
        wait_n(15);
        do_read(4'd1, v); chk("R5 falling trigger start", v, gw(1, 0, 3, smp[3]));

        // R3 R4 scan of channels 1,4,7 with code 3 (8 clocks, low 3 bits zero)
        do_write(4'd0, cw(8'h92, 0, 3, 1, 1, 0, 0));
        wait_n(9);
        do_read(4'd1, v); chk("R3 R4 scan first channel", v, gw(1, 0, 1, (smp[1] / 8) * 8));
        wait_n(7);
        do_read(4'd1, v); chk("R4 scan second channel", v, gw(1, 0, 4, (smp[4] / 8) * 8));
        wait_n(7);
        do_read(4'd1, v); chk("R4 scan third channel", v, gw(1, 0, 7, (smp[7] / 8) * 8));
        wait_n(7);
        do_read(4'd1, v); chk("R4 scan wraps", v, gw(1, 0, 1, (smp[1] / 8) * 8));
        do_write(4'd0, cw(8'h92, 0, 3, 0, 1, 0, 0));
        wait_n(20);
        do_read(4'd1, v); chk("R4 running conversion finishes", v, gw(1, 0, 4, (smp[4] / 8) * 8));
        wait_n(30);
        do_read(4'd1, v); chk("R4 scan stopped", v, gw(0, 0, 4, (smp[4] / 8) * 8));

        // R6 abort by power-down
        do_write(4'd0, cw(8'h01, 3, 0, 1, 1, 0, 0));
        wait_n(5);
        do_write(4'd0, cw(8'h01, 3, 0, 1, 0, 0, 0));
        wait_n(60);
        do_read(4'd1, v); chk("R6 aborted conversion not recorded", v, gw(0, 0, 4, (smp[4] / 8) * 8));
        do_read(4'd8, v); chk("R6 channel 0 untouched", v, 32'd0);

        wait_n(2);
        fin = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!fin) begin
            fin = 1'b1;
            checks++;
            failures++;
            $display("FAIL watchdog expired act=running exp=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule